// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one outgoing low-speed USB packet of 2 to 12 bytes onto the D+ and D- lines. It produces the leading sync byte itself. It fetches each later byte from a small external buffer through a read address, shifts every byte out least significant bit first, and line-codes the stream with NRZI and bit stuffing. It drives both pins and their output enable directly. Each bit is held for a fixed number of clocks: 10 clocks at a 15 MHz core clock gives the nominal 1.5 Mbit/s rate.

A client presents the byte count and a handshake flag and pulses `start`. The transmitter takes the bus by driving the idle J state for one bit time. It then sends every bit, closes the packet with a timed single-ended zero (SE0), drives J for one clock and lets go of the lines. In that final J clock it also commits a pending device address, but only after a data packet and never after a two-byte ACK or NAK reply. `busy` covers the whole sequence, and any request made while it is high is dropped.

Top module: `ls_pkt_sender`

## Requirements
- R1: Out of reset and whenever idle, `usb_oe`, `usb_dp`, `usb_dm`, `busy` and `addr_commit` are all 0.
- R2: In the cycle after `start` is sampled while idle, `usb_oe` rises and the lines show J (`usb_dp`=0, `usb_dm`=1). They hold J for exactly BIT_CLKS (10) clocks before the first bit.
- R3: The bits sent are the sync byte 0x80, then buffer entries 0 to `byte_count`-2 in order, each byte least significant bit first. Buffer entry j is read at `rd_addr`=j. Each bit slot lasts BIT_CLKS clocks.
- R4: NRZI: the level starts from J; a 0 bit inverts both lines relative to the previous slot, and a 1 bit repeats the previous level. K is `usb_dp`=1, `usb_dm`=0.
- R5: After six 1 bits in a row, one extra slot inverts the lines and resets the run before the next data bit is sent. The run carries across byte boundaries, and a stuffed slot also follows the last bit if the run reaches six there.
- R6: After the final slot, both lines are driven low with `usb_oe`=1 for exactly EOP_CLKS (20) clocks.
- R7: After the SE0, the lines show J for one clock. In the next cycle `usb_oe` is 0 and both lines are 0.
- R8: For a packet started with `handshake`=0, `addr_commit` is 1 during the final J clock, and `dev_addr` equals `pend_addr` from the next cycle. With `handshake`=1, `addr_commit` stays 0 and `dev_addr` is unchanged.
- R9: `busy` is 1 from the cycle after the start request through the final J clock. A `start` sampled while `busy` is 1 has no effect on the lines or on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send one packet, sampled only while idle |
| byte_count | input | 4 | Packet length including sync, 2 to 12 |
| handshake | input | 1 | 1 when the packet is an ACK/NAK reply |
| rd_addr | output | 4 | Buffer index of the next byte to fetch |
| rd_data | input | 8 | Buffer byte at `rd_addr` (combinational read) |
| pend_addr | input | 7 | Device address waiting to take effect |
| dev_addr | output | 7 | Active device address |
| addr_commit | output | 1 | Pulse in the final J clock of a data packet |
| usb_dp | output | 1 | D+ drive level |
| usb_dm | output | 1 | D- drive level |
| usb_oe | output | 1 | Output enable for both lines |
| busy | output | 1 | Transmission in progress |

## Verification
Two events can coincide in the last busy cycle: the address commit with the release of the bus, and a fresh start request arriving just as the transmitter finishes. The bench raises `start` so that it is sampled on the edge that leaves the final J clock. It then expects the lines to stay released and `busy` low, while `dev_addr` still takes the pending value. A second request placed in the middle of the bit stream must leave every later sample of the trace unchanged.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_SE0,
        ST_TAIL
    } tx_state_e;

    typedef struct packed {
        logic oe;
        logic dp;
        logic dm;
    } line_drv_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int unsigned STUFF_RUN = 6;

    // Pin drive for a given phase; lvl = 1 means J
    function automatic line_drv_t drive_for(tx_state_e st, logic lvl);
        line_drv_t d;
        d.oe = 1'b1;
        d.dp = 1'b0;
        d.dm = 1'b0;
        case (st)
            ST_IDLE: d.oe = 1'b0;
            ST_LEAD, ST_TAIL: d.dm = 1'b1;
            ST_BITS: begin
                d.dp = ~lvl;
                d.dm = lvl;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tx_slot_timer.sv
module tx_slot_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          tick
);
    logic [TW-1:0] tmr_q;

    assign tick = (tmr_q == limit - TW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear || tick) tmr_q <= '0;
        else                      tmr_q <= tmr_q + TW'(1);
    end

    // R6
    timer_range_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_q < limit);

endmodule

// File: rtl/tx_byte_feeder.sv
module tx_byte_feeder
    import usbtx_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int CW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] cnt_in,
    input  logic          advance,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          cur_bit,
    output logic          empty
);
    logic [7:0]    sh_q;
    logic [2:0]    bi_q;
    logic [CW-1:0] bx_q;
    logic [CW-1:0] cnt_q;
    logic          empty_q;

    assign cur_bit = sh_q[0];
    assign empty   = empty_q;
    assign rd_addr = AW'(bx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bi_q    <= '0;
            bx_q    <= '0;
            cnt_q   <= '0;
            empty_q <= 1'b1;
        end else if (load) begin
            sh_q    <= SYNC_BYTE;
            bi_q    <= '0;
            bx_q    <= '0;
            cnt_q   <= cnt_in;
            empty_q <= 1'b0;
        end else if (advance && !empty_q) begin
            if (bi_q == 3'd7) begin
                if ((bx_q + CW'(1)) < cnt_q) begin
                    sh_q <= rd_data;
                    bx_q <= bx_q + CW'(1);
                    bi_q <= '0;
                end else begin
                    empty_q <= 1'b1;
                end
            end else begin
                sh_q <= {1'b0, sh_q[7:1]};
                bi_q <= bi_q + 3'd1;
            end
        end
    end

    // R3
    byte_index_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bx_q) < MAX_BYTES);

endmodule

// File: rtl/tx_line_coder.sv
module tx_line_coder
    import usbtx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic slot,
    input  logic data_bit,
    output logic lvl,
    output logic stuff_due
);
    logic       lvl_q;
    logic [2:0] ones_q;

    assign lvl       = lvl_q;
    assign stuff_due = (ones_q == 3'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst || init) begin
            lvl_q  <= 1'b1;
            ones_q <= '0;
        end else if (slot) begin
            if (stuff_due || !data_bit) begin
                lvl_q  <= ~lvl_q;
                ones_q <= '0;
            end else begin
                ones_q <= ones_q + 3'd1;
            end
        end
    end

    // R5
    run_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ones_q <= 3'(STUFF_RUN));

endmodule

// File: rtl/ls_pkt_sender.sv
module ls_pkt_sender
    import usbtx_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int BIT_CLKS  = 10,
    parameter int EOP_CLKS  = 20,
    parameter int ADDR_W    = 7,
    localparam int CW = $clog2(MAX_BYTES + 1),
    localparam int AW = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CW-1:0]     byte_count,
    input  logic              handshake,
    output logic [AW-1:0]     rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] pend_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              addr_commit,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy
);
    localparam int MAXC = (EOP_CLKS > BIT_CLKS) ? EOP_CLKS : BIT_CLKS;
    localparam int TW   = $clog2(MAXC + 1);

    tx_state_e         st_q, st_d;
    logic              hs_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tick, load, slot, consume;
    logic              cur_bit, empty, lvl, stuff_due;
    logic [TW-1:0]     limit;
    line_drv_t         drv;

    assign load    = (st_q == ST_IDLE) && start;
    assign limit   = (st_q == ST_SE0) ? TW'(EOP_CLKS) : TW'(BIT_CLKS);
    assign slot    = tick && ((st_q == ST_LEAD) ||
                     ((st_q == ST_BITS) && (!empty || stuff_due)));
    assign consume = slot && !stuff_due;

    tx_slot_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (st_q == ST_IDLE),
        .limit (limit),
        .tick  (tick)
    );

    tx_byte_feeder #(.MAX_BYTES(MAX_BYTES), .CW(CW), .AW(AW)) u_feed (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cnt_in  (byte_count),
        .advance (consume),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .cur_bit (cur_bit),
        .empty   (empty)
    );

    tx_line_coder u_coder (
        .clk       (clk),
        .rst       (rst),
        .init      (load),
        .slot      (slot),
        .data_bit  (cur_bit),
        .lvl       (lvl),
        .stuff_due (stuff_due)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = ST_LEAD;
            ST_LEAD: if (tick) st_d = ST_BITS;
            ST_BITS: if (tick && empty && !stuff_due) st_d = ST_SE0;
            ST_SE0:  if (tick) st_d = ST_TAIL;
            ST_TAIL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hs_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) hs_q <= handshake;
            if (addr_commit) addr_q <= pend_addr;
        end
    end

    assign addr_commit = (st_q == ST_TAIL) && !hs_q;
    assign dev_addr    = addr_q;
    assign busy        = (st_q != ST_IDLE);
    assign drv         = drive_for(st_q, lvl);
    assign usb_oe      = drv.oe;
    assign usb_dp      = drv.dp;
    assign usb_dm      = drv.dm;

    // R2
    take_bus_j_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(usb_oe) |-> (!usb_dp && usb_dm));

    // R7
    release_after_j_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(usb_oe) |-> (!$past(usb_dp) && $past(usb_dm)));

    // R8
    addr_take_chk: assert property (@(posedge clk) disable iff (rst)
        addr_commit |=> (dev_addr == $past(pend_addr)));

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: tb/tb_ls_pkt_sender.sv
module tb_ls_pkt_sender;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] byte_count = 4'd2;
    logic       handshake = 1'b0;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic [6:0] pend_addr = '0;
    logic [6:0] dev_addr;
    logic       addr_commit, usb_dp, usb_dm, usb_oe, busy;

    logic [7:0] pkt_buf [0:15];
    bit         sym [0:255];
    int         nsym;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    logic [6:0] exp_addr = '0;

    always #4 clk = ~clk;

    assign rd_data = pkt_buf[rd_addr];

    ls_pkt_sender dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .handshake(handshake), .rd_addr(rd_addr), .rd_data(rd_data),
        .pend_addr(pend_addr), .dev_addr(dev_addr), .addr_commit(addr_commit),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected wire symbols: 1 = J, 0 = K (R3, R4, R5)
    task automatic build_syms(input int n);
        int lvl  = 1;
        int ones = 0;
        nsym = 0;
        for (int b = 0; b < n; b++) begin
            logic [7:0] by = (b == 0) ? 8'h80 : pkt_buf[b-1];
            for (int i = 0; i < 8; i++) begin
                if (by[i] == 1'b0) begin lvl = 1 - lvl; ones = 0; end
                else ones++;
                sym[nsym] = bit'(lvl); nsym++;
                if (ones == 6) begin
                    lvl = 1 - lvl; ones = 0;
                    sym[nsym] = bit'(lvl); nsym++;
                end
            end
        end
    endtask

    task automatic run_pkt(input int n, input int pat, input bit hs, input bit poke);
        int last;
        for (int j = 0; j < 16; j++) begin
            case (pat)
                0: pkt_buf[j] = 8'hFF;
                1: pkt_buf[j] = 8'h00;
                2: pkt_buf[j] = 8'(j * 37 + 5);
                3: pkt_buf[j] = 8'h7E ^ 8'(j);
                default: pkt_buf[j] = 8'hD2;
            endcase
        end
        build_syms(n);
        last = 30 + 10 * nsym;
        @(negedge clk);
        byte_count = 4'(n);
        handshake  = hs;
        pend_addr  = 7'(n * 9 + pat * 3 + (hs ? 1 : 0));
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s <= last + 3; s++) begin
            int eo, edp, edm, eb, ec;
            string rq;
            eb = 1; ec = 0; eo = 1;
            if (s < 10) begin
                edp = 0; edm = 1; rq = "R2";
            end else if (s < 10 + 10 * nsym) begin
                edm = int'(sym[(s - 10) / 10]); edp = 1 - edm; rq = "R4/R5 bits";
            end else if (s < last) begin
                edp = 0; edm = 0; rq = "R6";
            end else if (s == last) begin
                edp = 0; edm = 1; rq = "R7"; ec = hs ? 0 : 1;
            end else begin
                eo = 0; edp = 0; edm = 0; eb = 0; rq = "R1/R7/R9";
            end
            chk({usb_oe, usb_dp, usb_dm} == {eo[0], edp[0], edm[0]}, rq,
                "lines {oe,dp,dm}", int'({usb_oe, usb_dp, usb_dm}),
                int'({eo[0], edp[0], edm[0]}));
            chk(busy == eb[0], "R9", "busy", int'(busy), eb);
            chk(addr_commit == ec[0], "R8", "addr_commit", int'(addr_commit), ec);
            if (s == last + 1) begin
                if (!hs) exp_addr = pend_addr;
                chk(dev_addr == exp_addr, "R8", "dev_addr", int'(dev_addr), int'(exp_addr));
            end
            // R9: requests while busy, mid-stream and in the final J clock
            start = poke && (s == 14 || s == last);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int j = 0; j < 16; j++) pkt_buf[j] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({usb_oe, usb_dp, usb_dm, busy, addr_commit} == 5'b0, "R1", "idle outputs",
            int'({usb_oe, usb_dp, usb_dm, busy, addr_commit}), 0);
        chk(dev_addr == 7'd0, "R1", "dev_addr after reset", int'(dev_addr), 0);
        // R3 R4 R5: sweep lengths and patterns, data packets
        for (int n = 2; n <= 12; n++)
            for (int p = 0; p < 4; p++)
                run_pkt(n, p, 1'b0, (n + p) % 2 == 0);
        // R8: handshake replies leave the address untouched
        run_pkt(2, 4, 1'b1, 1'b1);
        run_pkt(2, 0, 1'b1, 1'b0);
        run_pkt(2, 4, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk(!busy && !usb_oe, "R9", "idle after last packet", int'(busy), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule